// File: doc/BRIEF.md
# Instruction Fetch Sampling Unit

This unit picks instruction fetches for profiling at a steady, programmable rate. It counts completed fetches and, once the programmed count is reached, tags the very next fetch that starts. It then follows that fetch by its ID, through the translation lookup, the instruction-cache lookup and any translation refill stall, until the fetch completes or aborts. At that point it freezes one sample and raises a one-cycle interrupt request.

The sample holds the fetch virtual address, whether the fetch completed, whether it was killed, the first translation and cache results, the fetch latency in cycles and the refill-stall cycle count. It stays valid and unchanged until software pulses a clear. While a sample waits, the unit tags no fetch and the period count holds. The clear restarts the period count from zero.

Top module: `fetch_sampler`

## Requirements
- R1: After reset, smp_valid and smp_irq are 0 and every sample field (address, flags, latency, refill) is 0.
- R2: A fetch is tagged only when its start pulse arrives in a cycle after the one that carried the Nth completed fetch, with N = period_max and a period_max of 0 treated as 1. A start that comes earlier, or in the same cycle as the Nth completion, is not tagged. While the unit waits for that start, completions do not count.
- R3: The tagged fetch ends on a completion or abort pulse carrying its ID. In the next cycle smp_valid is 1 and smp_irq is 1 for exactly that one cycle. smp_completed is 1 for a completion and 0 for an abort; when both arrive together the completion wins.
- R4: smp_latency is the number of clock edges from the edge that accepted the tagged start to the edge that accepted its end, so an end one cycle after the start gives 1. It saturates at 2^LAT_W-1.
- R5: smp_l1_miss, smp_l2_miss and smp_page_2m (1 = 2M page, 0 = 4K page) come from the first translation result carrying the tag ID, including one in the end cycle. They are 0 if no such result arrives.
- R6: smp_ic_miss comes from the first instruction-cache result carrying the tag ID, and is 0 if none arrives.
- R7: smp_killed is 1 exactly when no translation result with the tag ID arrived between the tag and the end (end cycle included).
- R8: smp_refill counts the cycles, from the cycle after the tag through the end cycle, in which refill_stall is 1. It is 0 when there is no stall and saturates at 2^LAT_W-1.
- R9: Translation, cache, completion and abort pulses that carry any other ID leave the sample unchanged.
- R10: While smp_valid is 1 and no clear arrives, the sample fields hold. No new fetch is tagged and no interrupt is raised, whatever fetch traffic arrives.
- R11: A sw_clear pulse while smp_valid is 1 drops smp_valid in the next cycle and restarts the period count from zero. A sw_clear pulse at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| period_max | input | PERIOD_W | Completed fetches per sampling period |
| start_vld | input | 1 | Fetch start pulse |
| start_id | input | ID_W | ID of the starting fetch |
| start_addr | input | ADDR_W | Virtual address of the starting fetch |
| xlat_vld | input | 1 | Translation lookup result pulse |
| xlat_id | input | ID_W | Fetch ID of the lookup |
| xlat_l1_miss | input | 1 | First-level translation buffer missed |
| xlat_l2_miss | input | 1 | Second-level translation buffer missed |
| xlat_page_2m | input | 1 | First-level translation used a 2M page (else 4K) |
| ic_vld | input | 1 | Instruction-cache lookup result pulse |
| ic_id | input | ID_W | Fetch ID of the cache lookup |
| ic_miss | input | 1 | Instruction cache missed |
| refill_stall | input | 1 | Fetch engine stalled for a translation refill |
| done_vld | input | 1 | Fetch completion pulse |
| done_id | input | ID_W | ID of the completing fetch |
| abort_vld | input | 1 | Fetch abort pulse |
| abort_id | input | ID_W | ID of the aborting fetch |
| sw_clear | input | 1 | Software clear pulse |
| smp_valid | output | 1 | A sample is held |
| smp_irq | output | 1 | One-cycle sampling interrupt request |
| smp_addr | output | ADDR_W | Sampled fetch address |
| smp_completed | output | 1 | Sampled fetch completed (0 = aborted) |
| smp_killed | output | 1 | Sampled fetch never reached translation |
| smp_l1_miss | output | 1 | Sampled first-level translation miss |
| smp_l2_miss | output | 1 | Sampled second-level translation miss |
| smp_page_2m | output | 1 | Sampled page size, 1 = 2M |
| smp_ic_miss | output | 1 | Sampled instruction-cache miss |
| smp_latency | output | LAT_W | Start-to-end cycles |
| smp_refill | output | LAT_W | Refill stall cycles |

## Verification
The end of the tagged fetch can fall in the same cycle as its translation result. The bench provokes this with a vector whose end arrives one cycle after the tag, together with its lookup, and expects the lookup flags, killed at 0 and a latency of 1. A second collision puts the Nth completion and a fetch start in one cycle; the bench then ends that fetch and checks that no sample appears, and only a later start's address is captured. A completion and an abort of the tagged ID in one cycle are also driven, and smp_completed must read 1.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
   typedef enum logic [1:0] {
      ST_COUNT = 2'd0,
      ST_HUNT  = 2'd1,
      ST_TRACK = 2'd2,
      ST_HOLD  = 2'd3
   } fsu_state_e;

   typedef struct packed {
      logic completed;
      logic killed;
      logic l1_miss;
      logic l2_miss;
      logic page_2m;
      logic ic_miss;
   } fsu_flags_t;
endpackage

// File: rtl/fsu_sat_cnt.sv
module fsu_sat_cnt #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] val,
   output logic [W-1:0] val_inc
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (SATURATE) begin : g_sat
         assign val_inc = (val == TOP) ? TOP : val + 1'b1;
      end else begin : g_wrap
         assign val_inc = val + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val <= '0;
      else if (clr)  val <= '0;
      else if (en)   val <= val_inc;
   end
endmodule

// File: rtl/fsu_period.sv
module fsu_period #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                count_en,
   input  logic [PERIOD_W-1:0] period_max,
   output logic                reached
);
   logic [PERIOD_W-1:0] cnt_val;
   logic [PERIOD_W-1:0] cnt_inc;
   logic [PERIOD_W-1:0] eff_max;
   logic [PERIOD_W:0]   next_cnt;

   assign eff_max  = (period_max == '0) ? {{(PERIOD_W-1){1'b0}}, 1'b1} : period_max;
   assign next_cnt = {1'b0, cnt_val} + 1'b1;
   assign reached  = count_en && (next_cnt >= {1'b0, eff_max});

   fsu_sat_cnt #(.W(PERIOD_W), .SATURATE(1'b1)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (restart | reached),
      .en      (count_en),
      .val     (cnt_val),
      .val_inc (cnt_inc)
   );

   // R2
   period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reached |=> (cnt_val == '0));
endmodule

// File: rtl/fsu_tracker.sv
module fsu_tracker #(
   parameter int ID_W  = 4,
   parameter int LAT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tag,
   input  logic [ID_W-1:0]  tag_id,
   input  logic             active,
   input  logic             xlat_vld,
   input  logic [ID_W-1:0]  xlat_id,
   input  logic             xlat_l1_miss,
   input  logic             xlat_l2_miss,
   input  logic             xlat_page_2m,
   input  logic             ic_vld,
   input  logic [ID_W-1:0]  ic_id,
   input  logic             ic_miss,
   input  logic             refill_stall,
   input  logic             done_vld,
   input  logic [ID_W-1:0]  done_id,
   input  logic             abort_vld,
   input  logic [ID_W-1:0]  abort_id,
   output logic             end_hit,
   output fsu_pkg::fsu_flags_t flags_n,
   output logic [LAT_W-1:0] lat_n,
   output logic [LAT_W-1:0] refill_n
);
   logic [ID_W-1:0] id_q;
   logic            reached_q, l1_q, l2_q, p2m_q;
   logic            icseen_q, icm_q;
   logic            xlat_hit, ic_hit, done_hit, abort_hit;
   logic            xlat_first, ic_first;
   logic [LAT_W-1:0] lat_val, lat_inc, ref_val, ref_inc;

   assign xlat_hit  = active && xlat_vld  && (xlat_id  == id_q);
   assign ic_hit    = active && ic_vld    && (ic_id    == id_q);
   assign done_hit  = active && done_vld  && (done_id  == id_q);
   assign abort_hit = active && abort_vld && (abort_id == id_q);
   assign xlat_first = xlat_hit && !reached_q;
   assign ic_first   = ic_hit && !icseen_q;
   assign end_hit    = done_hit || abort_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q      <= '0;
         reached_q <= 1'b0;
         l1_q      <= 1'b0;
         l2_q      <= 1'b0;
         p2m_q     <= 1'b0;
         icseen_q  <= 1'b0;
         icm_q     <= 1'b0;
      end else if (tag) begin
         id_q      <= tag_id;
         reached_q <= 1'b0;
         l1_q      <= 1'b0;
         l2_q      <= 1'b0;
         p2m_q     <= 1'b0;
         icseen_q  <= 1'b0;
         icm_q     <= 1'b0;
      end else begin
         if (xlat_first) begin
            reached_q <= 1'b1;
            l1_q      <= xlat_l1_miss;
            l2_q      <= xlat_l2_miss;
            p2m_q     <= xlat_page_2m;
         end
         if (ic_first) begin
            icseen_q <= 1'b1;
            icm_q    <= ic_miss;
         end
      end
   end

   fsu_sat_cnt #(.W(LAT_W), .SATURATE(1'b1)) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tag),
      .en      (active),
      .val     (lat_val),
      .val_inc (lat_inc)
   );

   fsu_sat_cnt #(.W(LAT_W), .SATURATE(1'b1)) u_refill (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tag),
      .en      (active && refill_stall),
      .val     (ref_val),
      .val_inc (ref_inc)
   );

   always_comb begin
      flags_n.completed = done_hit;
      flags_n.killed    = !(reached_q || xlat_hit);
      flags_n.l1_miss   = xlat_first ? xlat_l1_miss : l1_q;
      flags_n.l2_miss   = xlat_first ? xlat_l2_miss : l2_q;
      flags_n.page_2m   = xlat_first ? xlat_page_2m : p2m_q;
      flags_n.ic_miss   = ic_first ? ic_miss : icm_q;
      lat_n    = lat_inc;
      refill_n = refill_stall ? ref_inc : ref_val;
   end

   // R8
   refill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_val <= lat_val);
endmodule

// File: rtl/fetch_sampler.sv
module fetch_sampler #(
   parameter int ID_W     = 4,
   parameter int ADDR_W   = 48,
   parameter int PERIOD_W = 16,
   parameter int LAT_W    = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period_max,
   input  logic                start_vld,
   input  logic [ID_W-1:0]     start_id,
   input  logic [ADDR_W-1:0]   start_addr,
   input  logic                xlat_vld,
   input  logic [ID_W-1:0]     xlat_id,
   input  logic                xlat_l1_miss,
   input  logic                xlat_l2_miss,
   input  logic                xlat_page_2m,
   input  logic                ic_vld,
   input  logic [ID_W-1:0]     ic_id,
   input  logic                ic_miss,
   input  logic                refill_stall,
   input  logic                done_vld,
   input  logic [ID_W-1:0]     done_id,
   input  logic                abort_vld,
   input  logic [ID_W-1:0]     abort_id,
   input  logic                sw_clear,
   output logic                smp_valid,
   output logic                smp_irq,
   output logic [ADDR_W-1:0]   smp_addr,
   output logic                smp_completed,
   output logic                smp_killed,
   output logic                smp_l1_miss,
   output logic                smp_l2_miss,
   output logic                smp_page_2m,
   output logic                smp_ic_miss,
   output logic [LAT_W-1:0]    smp_latency,
   output logic [LAT_W-1:0]    smp_refill
);
   import fsu_pkg::*;

   generate
      if (ID_W < 1 || ID_W > 16) begin : g_bad_id
         $error("fetch_sampler: ID_W out of range");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("fetch_sampler: ADDR_W too small");
      end
      if (PERIOD_W < 2 || PERIOD_W > 32) begin : g_bad_period
         $error("fetch_sampler: PERIOD_W out of range");
      end
      if (LAT_W < 4 || LAT_W > 32) begin : g_bad_lat
         $error("fetch_sampler: LAT_W out of range");
      end
   endgenerate

   fsu_state_e         state_q, state_d;
   logic               reached, tag, capture, clear_ok;
   logic [ADDR_W-1:0]  tag_addr_q;
   logic               end_hit;
   fsu_flags_t         flags_n, flags_q;
   logic [LAT_W-1:0]   lat_n, refill_n;

   assign tag      = (state_q == ST_HUNT) && start_vld;
   assign capture  = (state_q == ST_TRACK) && end_hit;
   assign clear_ok = (state_q == ST_HOLD) && sw_clear;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_COUNT: if (reached)  state_d = ST_HUNT;
         ST_HUNT:  if (tag)      state_d = ST_TRACK;
         ST_TRACK: if (capture)  state_d = ST_HOLD;
         ST_HOLD:  if (clear_ok) state_d = ST_COUNT;
         default:                state_d = ST_COUNT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_COUNT;
      else        state_q <= state_d;
   end

   fsu_period #(.PERIOD_W(PERIOD_W)) u_period (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (clear_ok),
      .count_en   ((state_q == ST_COUNT) && done_vld),
      .period_max (period_max),
      .reached    (reached)
   );

   fsu_tracker #(.ID_W(ID_W), .LAT_W(LAT_W)) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .tag          (tag),
      .tag_id       (start_id),
      .active       (state_q == ST_TRACK),
      .xlat_vld     (xlat_vld),
      .xlat_id      (xlat_id),
      .xlat_l1_miss (xlat_l1_miss),
      .xlat_l2_miss (xlat_l2_miss),
      .xlat_page_2m (xlat_page_2m),
      .ic_vld       (ic_vld),
      .ic_id        (ic_id),
      .ic_miss      (ic_miss),
      .refill_stall (refill_stall),
      .done_vld     (done_vld),
      .done_id      (done_id),
      .abort_vld    (abort_vld),
      .abort_id     (abort_id),
      .end_hit      (end_hit),
      .flags_n      (flags_n),
      .lat_n        (lat_n),
      .refill_n     (refill_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_addr_q  <= '0;
         smp_valid   <= 1'b0;
         smp_irq     <= 1'b0;
         smp_addr    <= '0;
         flags_q     <= '0;
         smp_latency <= '0;
         smp_refill  <= '0;
      end else begin
         smp_irq <= capture;
         if (tag) tag_addr_q <= start_addr;
         if (capture) begin
            smp_valid   <= 1'b1;
            smp_addr    <= tag_addr_q;
            flags_q     <= flags_n;
            smp_latency <= lat_n;
            smp_refill  <= refill_n;
         end else if (clear_ok) begin
            smp_valid <= 1'b0;
         end
      end
   end

   assign smp_completed = flags_q.completed;
   assign smp_killed    = flags_q.killed;
   assign smp_l1_miss   = flags_q.l1_miss;
   assign smp_l2_miss   = flags_q.l2_miss;
   assign smp_page_2m   = flags_q.page_2m;
   assign smp_ic_miss   = flags_q.ic_miss;

   // R3
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_irq |=> !smp_irq);

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !sw_clear) |=> (smp_valid && $stable(smp_addr) && $stable(smp_latency)));

   // R10
   no_tag_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag |-> !smp_valid);

   // R11
   clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && sw_clear) |=> !smp_valid);

   // R8
   refill_le_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (smp_refill <= smp_latency));
endmodule

// File: tb/sim_fetch_sampler.sv
`timescale 1ns/1ps
module sim_fetch_sampler;
   localparam int ID_W = 4, ADDR_W = 48, PERIOD_W = 16, LAT_W = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [PERIOD_W-1:0] period_max = '0;
   logic start_vld = 0, xlat_vld = 0, ic_vld = 0, done_vld = 0, abort_vld = 0;
   logic [ID_W-1:0] start_id = '0, xlat_id = '0, ic_id = '0, done_id = '0, abort_id = '0;
   logic [ADDR_W-1:0] start_addr = '0;
   logic xlat_l1_miss = 0, xlat_l2_miss = 0, xlat_page_2m = 0, ic_miss = 0;
   logic refill_stall = 0, sw_clear = 0;
   logic smp_valid, smp_irq, smp_completed, smp_killed;
   logic smp_l1_miss, smp_l2_miss, smp_page_2m, smp_ic_miss;
   logic [ADDR_W-1:0] smp_addr;
   logic [LAT_W-1:0] smp_latency, smp_refill;

   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   fetch_sampler #(.ID_W(ID_W), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W), .LAT_W(LAT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .period_max(period_max),
      .start_vld(start_vld), .start_id(start_id), .start_addr(start_addr),
      .xlat_vld(xlat_vld), .xlat_id(xlat_id), .xlat_l1_miss(xlat_l1_miss),
      .xlat_l2_miss(xlat_l2_miss), .xlat_page_2m(xlat_page_2m),
      .ic_vld(ic_vld), .ic_id(ic_id), .ic_miss(ic_miss), .refill_stall(refill_stall),
      .done_vld(done_vld), .done_id(done_id), .abort_vld(abort_vld), .abort_id(abort_id),
      .sw_clear(sw_clear), .smp_valid(smp_valid), .smp_irq(smp_irq), .smp_addr(smp_addr),
      .smp_completed(smp_completed), .smp_killed(smp_killed), .smp_l1_miss(smp_l1_miss),
      .smp_l2_miss(smp_l2_miss), .smp_page_2m(smp_page_2m), .smp_ic_miss(smp_ic_miss),
      .smp_latency(smp_latency), .smp_refill(smp_refill));

   typedef struct packed {
      logic [7:0]  period;
      logic [3:0]  id;
      logic [15:0] addr;
      logic xl, l1, l2, p2m, icv, icm, abt, noise;
      logic [7:0]  k;
      logic [7:0]  stall;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'd3, 4'd5,  16'h1234, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0, 1'b0,1'b0, 8'd4, 8'd0},
      '{8'd1, 4'd2,  16'hABCD, 1'b1,1'b1,1'b0,1'b1, 1'b1,1'b1, 1'b0,1'b1, 8'd6, 8'd2},
      '{8'd0, 4'd7,  16'h0F0F, 1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0, 1'b1,1'b1, 8'd3, 8'd3},
      '{8'd5, 4'd9,  16'h5555, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 8'd2, 8'd1},
      '{8'd2, 4'd3,  16'h00FF, 1'b1,1'b1,1'b0,1'b1, 1'b1,1'b1, 1'b0,1'b0, 8'd1, 8'd1},
      '{8'd4, 4'd12, 16'hBEEF, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, 1'b1,1'b0, 8'd5, 8'd5}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      start_vld = 0; xlat_vld = 0; ic_vld = 0; done_vld = 0; abort_vld = 0;
      sw_clear = 0; refill_stall = 0;
      xlat_l1_miss = 0; xlat_l2_miss = 0; xlat_page_2m = 0; ic_miss = 0;
   endtask

   task automatic done_pulse(input logic [3:0] id);
      done_vld = 1; done_id = id; step();
   endtask

   task automatic start_pulse(input logic [3:0] id, input logic [47:0] a);
      start_vld = 1; start_id = id; start_addr = a; step();
   endtask

   task automatic clear_pulse();
      sw_clear = 1; step();
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 valid", smp_valid, 0);
      check("R1 irq", smp_irq, 0);
      check("R1 fields", {smp_addr, smp_latency, smp_refill, smp_completed, smp_killed,
                          smp_l1_miss, smp_l2_miss, smp_page_2m, smp_ic_miss}, 0);
      rst_n = 1;
      step();

      for (int v = 0; v < 6; v++) begin
         vec_t t;
         int np;
         t = VECS[v];
         period_max = {8'd0, t.period};
         np = (t.period == 0) ? 1 : int'(t.period);
         for (int n = 0; n < np; n++) done_pulse(4'd15);
         start_pulse(t.id, {32'd0, t.addr});
         for (int j = 1; j <= int'(t.k); j++) begin
            refill_stall = (j <= int'(t.stall));
            if (j == 1 && t.xl) begin
               xlat_vld = 1; xlat_id = t.id;
               xlat_l1_miss = t.l1; xlat_l2_miss = t.l2; xlat_page_2m = t.p2m;
            end else if (j == 1 && t.noise) begin
               // R9 lookup of another ID
               xlat_vld = 1; xlat_id = t.id ^ 4'd1; xlat_l1_miss = 1; xlat_l2_miss = 1;
            end
            if (j == 1 && t.icv) begin
               ic_vld = 1; ic_id = t.id; ic_miss = t.icm;
            end else if (j == 1 && t.noise) begin
               ic_vld = 1; ic_id = t.id ^ 4'd1; ic_miss = 1;
            end
            if (j == int'(t.k)) begin
               if (t.abt) begin abort_vld = 1; abort_id = t.id; end
               else begin done_vld = 1; done_id = t.id; end
            end else if (t.noise) begin
               // R9 completion and abort of another ID
               done_vld = 1; done_id = t.id ^ 4'd1;
               abort_vld = 1; abort_id = t.id ^ 4'd1;
            end
            step();
         end
         check("R3 valid", smp_valid, 1);
         check("R3 irq", smp_irq, 1);
         check("R3 completed", smp_completed, !t.abt);
         check("R9 addr", smp_addr, {32'd0, t.addr});
         check("R4 latency", smp_latency, t.k);
         check("R5 xlat flags", {smp_l1_miss, smp_l2_miss, smp_page_2m},
               {t.xl & t.l1, t.xl & t.l2, t.xl & t.p2m});
         check("R6 ic miss", smp_ic_miss, t.icv & t.icm);
         check("R7 killed", smp_killed, !t.xl);
         check("R8 refill", smp_refill, (t.stall < t.k) ? t.stall : t.k);
         step();
         check("R3 irq one cycle", smp_irq, 0);
         check("R10 valid held", smp_valid, 1);
         clear_pulse();
         check("R11 valid cleared", smp_valid, 0);
      end

      // R2 early start not tagged
      period_max = 16'd3;
      done_pulse(4'd15);
      done_pulse(4'd15);
      start_pulse(4'd4, 48'h111);
      done_pulse(4'd4);
      check("R2 early start untagged", smp_valid, 0);
      start_pulse(4'd6, 48'h222);
      done_pulse(4'd6);
      check("R2 next start tagged", smp_addr, 48'h222);
      check("R4 latency one", smp_latency, 1);
      clear_pulse();

      // R2 start in the same cycle as the Nth completion; R3 both ends together
      period_max = 16'd1;
      done_vld = 1; done_id = 4'd15; start_vld = 1; start_id = 4'd8; start_addr = 48'h333;
      step();
      done_pulse(4'd8);
      check("R2 same-cycle start untagged", smp_valid, 0);
      start_pulse(4'd9, 48'h444);
      done_vld = 1; done_id = 4'd9; abort_vld = 1; abort_id = 4'd9;
      step();
      check("R2 later start captured", smp_addr, 48'h444);
      check("R3 completion wins", smp_completed, 1);

      // R10 pending sample ignores traffic
      for (int i = 0; i < 4; i++) begin
         start_vld = 1; start_id = 4'd2; start_addr = 48'h999;
         done_vld = 1; done_id = 4'd2;
         step();
         check("R10 addr held", smp_addr, 48'h444);
         check("R10 no irq", smp_irq, 0);
      end
      period_max = 16'd2;
      clear_pulse();
      check("R11 clear drops valid", smp_valid, 0);
      done_pulse(4'd15);
      start_pulse(4'd3, 48'h555);
      done_pulse(4'd3);
      check("R11 count restarted", smp_valid, 0);
      start_pulse(4'd4, 48'h666);
      done_pulse(4'd4);
      check("R11 period of two", smp_addr, 48'h666);
      clear_pulse();

      // R11 clear while tracking is ignored
      period_max = 16'd1;
      done_pulse(4'd15);
      start_pulse(4'd5, 48'h777);
      clear_pulse();
      done_pulse(4'd5);
      check("R11 stray clear ignored", smp_valid, 1);
      check("R4 latency two", smp_latency, 2);
      clear_pulse();

      // R4 / R8 saturation
      done_pulse(4'd15);
      start_pulse(4'd6, 48'h888);
      for (int i = 0; i < 5000; i++) begin
         refill_stall = 1; step();
      end
      refill_stall = 1; done_vld = 1; done_id = 4'd6;
      step();
      check("R4 latency saturates", smp_latency, 12'hFFF);
      check("R8 refill saturates", smp_refill, 12'hFFF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule